// File: doc/BRIEF.md
# Clock Mode Auto-Switch Controller

This block manages the system clock speed of a small microcontroller. There are three speeds: high, middle and low. High and middle speed run from the main oscillator through fixed dividers. Low speed runs from the sub-clock, divided by two. The block does not produce real clocks. It produces a one-cycle strobe, `phi_stb`, for each internal clock period. The fabric clock `clk` samples the two oscillators as tick enables.

The CPU reaches two 8-bit registers through a small write/read port:

- **Control register** (address 0): an option bit for oscillator stabilisation after stop, an auto-switch enable, a wait-length select and a start bit.
- **Mode register** (address 1): the speed field, a main-oscillator stop bit and a sub-clock select bit.

The CPU may set the start bit while the chip runs at low speed with auto-switch enabled. The block then turns the main oscillator back on and counts internal clock strobes. After a short or long wait it rewrites the speed field to middle speed by itself, with no further software action.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the mode register reads 0x40 (speed field 01 = middle), `speed_o` is 01, `main_osc_en` is 1 and no switch is pending.
- R2: `cpu_addr` 0 selects the control register and 1 selects the mode register. `cpu_rdata` shows the selected register one cycle after the address is presented. Control bits 7:4 and mode bits 3:0 always read 0.
- R3: Control bit 0 (stabilisation option), bit 1 (auto-switch enable) and bit 2 (wait select) read back as written.
- R4: Control bit 3 (start) is taken as 1 only when all of the following hold:
  - the written byte has both bit 3 and bit 1 set;
  - the speed field (mode bits 7:6) is 10 = low;
  - mode bit 4 (sub-clock select) is 1;
  - no switch is pending.
  Otherwise it reads 0 and nothing else changes.
- R5: An accepted start clears mode bit 5 (main-oscillator stop), so `main_osc_en` is 1 from the next cycle.
- R6: After an accepted start, the speed field stays 10 until the Nth `phi_stb`. N is 5 when wait select was 0 at start, and 7 when it was 1. In the cycle after that strobe, the speed field reads 01 and the start bit reads 0.
- R7: Any write to the mode register while a switch is pending takes the written value, clears the start bit and cancels the switch.
- R8: `phi_stb` pulses in the cycle after a qualifying tick:
  - speed 00: every 2nd counted main tick;
  - speed 01 or 11: every 8th counted main tick;
  - speed 10 with sub-clock select 1: every 2nd sub tick, counted since reset;
  - speed 10 with sub-clock select 0: never.
- R9: `main_osc_en` is 1 whenever the speed field is not 10. At speed 10 it is the inverse of mode bit 5. Main ticks arriving while it is 0 are not counted.
- R10: Control-register writes while a switch is pending change neither the start bit nor the wait length latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 control, 1 mode |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| xin_tick | input | 1 | One-cycle pulse per main oscillator period |
| xcin_tick | input | 1 | One-cycle pulse per sub-clock period |
| phi_stb | output | 1 | Internal clock period strobe |
| main_osc_en | output | 1 | Main oscillator enable |
| speed_o | output | 2 | Current speed field |

## Verification
The bench builds the block with its default parameters: dividers 2, 8 and 2, and waits of 5 and 7 strobes. These small values let a short run cover every divider phase in each speed setting. The run also covers both wait lengths, each started on both phases of the sub-clock divider. Rejected starts, cancellation and writes made while a switch is pending are all checked at the register port and the speed output.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  localparam int CTL_STAB_B   = 0;
  localparam int CTL_AUTO_B   = 1;
  localparam int CTL_WSEL_B   = 2;
  localparam int CTL_START_B  = 3;
  localparam int MOD_SUBSEL_B = 4;
  localparam int MOD_MSTOP_B  = 5;
  localparam int MOD_SPD_LSB  = 6;

  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_MODE = 1'b1;
endpackage

// File: rtl/clkmode_strobe.sv
module clkmode_strobe
  import clkmode_pkg::*;
#(
  parameter int HI_DIV  = 2,
  parameter int MID_DIV = 8,
  parameter int SUB_DIV = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   xin_tick,
  input  logic   xcin_tick,
  input  logic   osc_en,
  input  speed_e speed,
  input  logic   subsel,
  output logic   phi_stb
);
  localparam int MW = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

  logic [MW-1:0] mcnt_q;
  logic [SW-1:0] scnt_q;
  logic mtick, m_hi_last, m_mid_last, s_last, phi_d;

  always_comb begin
    mtick      = xin_tick & osc_en;
    m_hi_last  = ((int'(mcnt_q) % HI_DIV) == (HI_DIV - 1));
    m_mid_last = (mcnt_q == MW'(MID_DIV - 1));
    s_last     = (scnt_q == SW'(SUB_DIV - 1));
    case (speed)
      SPD_HIGH: phi_d = mtick & m_hi_last;
      SPD_LOW:  phi_d = xcin_tick & subsel & s_last;
      default:  phi_d = mtick & m_mid_last;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt_q  <= '0;
      scnt_q  <= '0;
      phi_stb <= 1'b0;
    end else begin
      phi_stb <= phi_d;
      if (mtick) mcnt_q <= m_mid_last ? '0 : mcnt_q + MW'(1);
      if (xcin_tick) scnt_q <= s_last ? '0 : scnt_q + SW'(1);
    end
  end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
#(
  parameter int WAIT_SHORT = 5,
  parameter int WAIT_LONG  = 7
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   ctl_wr,
  input  logic   mode_wr,
  input  logic   wr_start,
  input  logic   wr_auto,
  input  logic   wr_wsel,
  input  speed_e speed,
  input  logic   subsel,
  input  logic   phi_stb,
  output logic   arm,
  output logic   done,
  output logic   busy
);
  localparam int WMAX = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
  localparam int CW   = $clog2(WMAX + 1);

  logic [CW-1:0] cnt_q, goal_q;
  logic busy_q;

  always_comb begin
    arm  = ctl_wr & wr_start & wr_auto & (speed == SPD_LOW) & subsel & ~busy_q;
    done = busy_q & phi_stb & ~mode_wr & ((cnt_q + CW'(1)) == goal_q);
    busy = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      goal_q <= '0;
    end else if (arm) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      goal_q <= wr_wsel ? CW'(WAIT_LONG) : CW'(WAIT_SHORT);
    end else if (busy_q) begin
      if (mode_wr || done) busy_q <= 1'b0;
      else if (phi_stb) cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic       mode_wr,
  input  logic       rd_addr,
  input  logic [7:0] wr_data,
  input  logic       arm,
  input  logic       done,
  input  logic       busy,
  output logic [3:0] ctl_q,
  output speed_e     speed_q,
  output logic       subsel_q,
  output logic       mstop_q,
  output logic [7:0] rdata
);
  logic [7:0] ctl_view, mode_view;

  always_comb begin
    ctl_view  = {4'b0000, ctl_q};
    mode_view = {speed_q, mstop_q, subsel_q, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      speed_q  <= SPD_MID;
      subsel_q <= 1'b0;
      mstop_q  <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata <= (rd_addr == ADDR_MODE) ? mode_view : ctl_view;
      if (ctl_wr) begin
        ctl_q[CTL_STAB_B] <= wr_data[CTL_STAB_B];
        ctl_q[CTL_AUTO_B] <= wr_data[CTL_AUTO_B];
        ctl_q[CTL_WSEL_B] <= wr_data[CTL_WSEL_B];
        if (!busy) ctl_q[CTL_START_B] <= arm;
      end
      if (mode_wr) begin
        speed_q  <= speed_e'(wr_data[MOD_SPD_LSB +: 2]);
        mstop_q  <= wr_data[MOD_MSTOP_B];
        subsel_q <= wr_data[MOD_SUBSEL_B];
        if (busy) ctl_q[CTL_START_B] <= 1'b0;
      end else if (done) begin
        speed_q <= SPD_MID;
        ctl_q[CTL_START_B] <= 1'b0;
      end
      if (arm) mstop_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int HI_DIV     = 2,
  parameter int MID_DIV    = 8,
  parameter int SUB_DIV    = 2,
  parameter int WAIT_SHORT = 5,
  parameter int WAIT_LONG  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_we,
  input  logic       cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       xin_tick,
  input  logic       xcin_tick,
  output logic       phi_stb,
  output logic       main_osc_en,
  output logic [1:0] speed_o
);
  logic       ctl_wr, mode_wr;
  logic       arm, done, busy;
  logic [3:0] ctl_q;
  speed_e     speed_q;
  logic       subsel_q, mstop_q;

  always_comb begin
    ctl_wr      = cpu_we & (cpu_addr == ADDR_CTL);
    mode_wr     = cpu_we & (cpu_addr == ADDR_MODE);
    main_osc_en = (speed_q != SPD_LOW) | ~mstop_q;
    speed_o     = speed_q;
  end

  clkmode_regs u_regs (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .mode_wr(mode_wr),
    .rd_addr(cpu_addr), .wr_data(cpu_wdata), .arm(arm), .done(done),
    .busy(busy), .ctl_q(ctl_q), .speed_q(speed_q), .subsel_q(subsel_q),
    .mstop_q(mstop_q), .rdata(cpu_rdata)
  );

  clkmode_seq #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .mode_wr(mode_wr),
    .wr_start(cpu_wdata[CTL_START_B]), .wr_auto(cpu_wdata[CTL_AUTO_B]),
    .wr_wsel(cpu_wdata[CTL_WSEL_B]), .speed(speed_q), .subsel(subsel_q),
    .phi_stb(phi_stb), .arm(arm), .done(done), .busy(busy)
  );

  clkmode_strobe #(.HI_DIV(HI_DIV), .MID_DIV(MID_DIV), .SUB_DIV(SUB_DIV)) u_strobe (
    .clk(clk), .rst(rst), .xin_tick(xin_tick), .xcin_tick(xcin_tick),
    .osc_en(main_osc_en), .speed(speed_q), .subsel(subsel_q),
    .phi_stb(phi_stb)
  );
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] speed,
  input logic       start_bit,
  input logic       mode_wr,
  input logic       main_osc_en,
  input logic       phi_stb,
  input logic       xcin_tick,
  input logic       subsel,
  input logic       cpu_addr,
  input logic [7:0] cpu_rdata
);
  // R2: unused nibble of each register reads zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ($past(cpu_addr) ? (cpu_rdata[3:0] == 4'h0) : (cpu_rdata[7:4] == 4'h0)));

  // R4: a set start bit implies low speed
  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    start_bit |-> (speed == 2'b10));

  // R9: oscillator always on outside low speed
  p_osc_on_r9: assert property (@(posedge clk) disable iff (rst)
    (speed != 2'b10) |-> main_osc_en);

  // R6: leaving low speed without a mode write lands in middle speed
  p_auto_mid_r6: assert property (@(posedge clk) disable iff (rst)
    (($past(speed) == 2'b10) && (speed != 2'b10) && !$past(mode_wr)) |-> (speed == 2'b01));

  // R8: low-speed strobes come only from selected sub ticks
  p_low_src_r8: assert property (@(posedge clk) disable iff (rst)
    (phi_stb && ($past(speed) == 2'b10)) |-> $past(xcin_tick && subsel));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .speed(speed_o), .start_bit(ctl_q[3]),
  .mode_wr(mode_wr), .main_osc_en(main_osc_en), .phi_stb(phi_stb),
  .xcin_tick(xcin_tick), .subsel(subsel_q), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata)
);

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 1'b0;
  logic       cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic       xin_tick = 1'b0;
  logic       xcin_tick = 1'b0;
  logic [7:0] cpu_rdata;
  logic       phi_stb, main_osc_en;
  logic [1:0] speed_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // model state derived from the requirements
  logic [1:0] m_spd = 2'b01;
  bit m_sub = 0, m_stop = 0, m_pend = 0;
  logic [2:0] m_ctl = 3'b000;
  int m_goal = 0, m_pcnt = 0, m_mcnt = 0, m_scnt = 0;

  always #5 clk = ~clk;

  clkmode_ctrl u_clkmode_ctrl (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xin_tick(xin_tick),
    .xcin_tick(xcin_tick), .phi_stb(phi_stb), .main_osc_en(main_osc_en),
    .speed_o(speed_o)
  );

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit osc_model();
    return (m_spd != 2'b10) || !m_stop;
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    if (a) begin
      m_spd = d[7:6]; m_stop = d[5]; m_sub = d[4];
      m_pend = 0;
    end else begin
      if (d[3] && d[1] && m_spd == 2'b10 && m_sub && !m_pend) begin
        m_pend = 1; m_pcnt = 0; m_stop = 0;
        m_goal = d[2] ? 7 : 5;
      end
      m_ctl = d[2:0];
    end
  endtask

  task automatic rd(input logic a, input string req);
    int exp;
    cpu_addr = a;
    @(negedge clk);
    exp = a ? {m_spd, m_stop, m_sub, 4'b0000} : {4'b0000, m_pend, m_ctl};
    check(req, cpu_rdata, exp);
  endtask

  task automatic main_tick(input string req);
    int exp;
    exp = 0;
    xin_tick = 1'b1;
    @(negedge clk);
    xin_tick = 1'b0;
    if (osc_model()) begin
      m_mcnt++;
      if (m_spd == 2'b00) exp = (m_mcnt % 2 == 0);
      else if (m_spd != 2'b10) exp = (m_mcnt % 8 == 0);
    end
    check(req, phi_stb, exp);
    @(negedge clk);
  endtask

  task automatic sub_tick(input string req);
    int exp;
    xcin_tick = 1'b1;
    @(negedge clk);
    xcin_tick = 1'b0;
    m_scnt++;
    exp = (m_spd == 2'b10) && m_sub && (m_scnt % 2 == 0);
    check(req, phi_stb, exp);
    if (exp && m_pend) begin
      m_pcnt++;
      if (m_pcnt == m_goal) begin m_spd = 2'b01; m_pend = 0; end
    end
    @(negedge clk);
    check(req, speed_o, m_spd);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 speed", speed_o, 2'b01);
    check("R1 osc", main_osc_en, 1);
    rd(1'b0, "R1 ctl");
    rd(1'b1, "R1 mode");

    // R2 / R3 register access, R4 rejected start outside low speed
    wr(1'b0, 8'hF7); rd(1'b0, "R3 ctl bits");
    wr(1'b0, 8'hFF); rd(1'b0, "R4 start outside low");
    wr(1'b0, 8'h00); rd(1'b0, "R3 ctl clear");
    wr(1'b1, 8'h4F); rd(1'b1, "R2 mode low nibble");

    // R8 main-clock strobe sweep for each main speed setting
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      wr(1'b1, 8'(s << 6));
      for (int k = 0; k < 16; k++) main_tick("R8 main strobe");
      for (int k = 0; k < 3; k++) sub_tick("R8 sub ignored");
    end

    // R8 low speed without sub-clock select, R4 rejected start
    wr(1'b1, 8'h80);
    for (int k = 0; k < 4; k++) sub_tick("R8 no subsel");
    wr(1'b0, 8'h0A); rd(1'b0, "R4 start without subsel");
    check("R4 speed kept", speed_o, 2'b10);

    // R9 oscillator stopped, main ticks not counted
    wr(1'b1, 8'hB0);
    check("R9 osc off", main_osc_en, 0);
    for (int k = 0; k < 5; k++) main_tick("R9 gated tick");
    for (int k = 0; k < 4; k++) sub_tick("R8 low strobe");
    wr(1'b0, 8'h08); rd(1'b0, "R4 start without enable");
    check("R4 osc still off", main_osc_en, 0);

    // R5 / R6 / R10 automatic switch, both waits, both sub phases
    for (int ws = 0; ws < 2; ws++) begin
      for (int ph = 0; ph < 2; ph++) begin
        wr(1'b1, 8'hB0);
        if (ph == 1) sub_tick("R8 phase shift");
        wr(1'b0, 8'(8'h0A | (ws << 2)));
        check("R5 osc on", main_osc_en, 1);
        rd(1'b0, "R4 start accepted");
        if (ph == 1) begin
          wr(1'b0, 8'(ws == 0 ? 8'h0F : 8'h03));
          rd(1'b0, "R10 start held");
        end
        for (int k = 0; k < 20 && m_pend; k++) sub_tick("R6 wait count");
        check("R6 speed mid", speed_o, 2'b01);
        rd(1'b1, "R6 mode readback");
        rd(1'b0, "R6 start cleared");
        for (int k = 0; k < 8; k++) main_tick("R8 mid after switch");
      end
    end

    // R7 cancel by mode write
    wr(1'b1, 8'hB0);
    wr(1'b0, 8'h0A);
    sub_tick("R7 pending");
    sub_tick("R7 pending");
    wr(1'b1, 8'h90);
    rd(1'b0, "R7 start cleared");
    for (int k = 0; k < 14; k++) sub_tick("R7 no switch");
    rd(1'b1, "R7 mode kept");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule